// File: doc/BRIEF.md
# Amplitude Threshold Monitor

This block watches a single-bit sigma-delta modulator stream through a short, fast sinc decimator and turns it into a 16-bit unsigned amplitude. Each new amplitude goes to three comparators: a high limit, a low limit and a rising zero-crossing detector with its own enable. A fourth event, modulator failure, comes from an external clock-missing indication. All four events land in sticky flags that software clears by writing 1. Three of them (high, low, failure) can each raise the interrupt output through their own enable.

The filter order and decimation ratio are static while the path is enabled. Dropping the enable clears the filter, the decimation counter, the amplitude and the ignore counter. The flags are not touched. A programmable number of first outputs after enable still update the amplitude, but they do not take part in comparisons. This keeps the filter's start-up transient from raising false limit events.

Top module: `amp_threshold_monitor`

## Requirements
- R1: The decimation ratio R is `dec_ratio`, with 0 meaning 32. With `filt_order` = 0 (first order), each amplitude is the count of 1 bits among the last R accepted samples. A sample is accepted when `bit_vld` is high; a 1 bit weighs +1 and a 0 bit weighs 0.
- R2: `filt_order` = 1 gives the second-order response: the sum of the last 2R-1 samples with triangular weights. `filt_order` = 2 gives the third-order response: box weights convolved three times, spanning 3R-2 samples. Samples before enable count as 0.
- R3: `filt_order` = 3 selects the fast variant. Its amplitude is the second-order result multiplied by R, so its full scale matches the third-order one.
- R4: `amp` updates at the clock edge that accepts every R-th sample after enable, and `amp_vld` is high for the following cycle. While `path_en` is low, `amp` reads 0 and `amp_vld` stays low.
- R5: The first `skip_cnt` amplitudes after enable are excluded from all three comparisons.
- R6: Flag bit 0 sets when a compared amplitude is greater than `thr_high` (unsigned). The flag appears one cycle after `amp_vld`.
- R7: Flag bit 1 sets when a compared amplitude is less than `thr_low` (unsigned).
- R8: When `zc_en` is high, flag bit 2 sets if the previous amplitude was at or below `thr_zero` and the compared one is above it. The previous amplitude is 0 right after enable.
- R9: Flag bit 3 sets one cycle after any cycle in which `path_en` and `mclk_lost` are both high.
- R10: Every flag is sticky. A 1 in `flag_clr` at the flag's bit position clears it, unless the same cycle sets it, in which case it stays set. All flags reset to 0.
- R11: `irq` is high exactly when (flag 0 and `ie_high`), (flag 1 and `ie_low`) or (flag 3 and `ie_fail`) holds. The zero-crossing flag never drives `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| path_en | input | 1 | Path enable; low clears filter state and amplitude |
| bit_vld | input | 1 | Modulator sample strobe |
| bit_in | input | 1 | Modulator sample bit |
| filt_order | input | 2 | 0 first, 1 second, 2 third order, 3 fast |
| dec_ratio | input | 5 | Decimation ratio, 0 means 32 |
| skip_cnt | input | 3 | Number of initial amplitudes excluded from comparison |
| thr_high | input | 16 | High-limit threshold |
| thr_low | input | 16 | Low-limit threshold |
| thr_zero | input | 16 | Zero-crossing threshold |
| zc_en | input | 1 | Zero-crossing detection enable |
| ie_high | input | 1 | Interrupt enable for the high-limit flag |
| ie_low | input | 1 | Interrupt enable for the low-limit flag |
| ie_fail | input | 1 | Interrupt enable for the failure flag |
| mclk_lost | input | 1 | External modulator clock missing indication |
| flag_clr | input | 4 | Write-1-to-clear strobes, one per flag bit |
| amp | output | 16 | Current amplitude |
| amp_vld | output | 1 | One-cycle strobe after each amplitude update |
| flags | output | 4 | Sticky flags: 0 high, 1 low, 2 zero crossing, 3 failure |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives a third-order filter with an all-ones stream at ratio 32, so the amplitude reaches exactly 32768. A design that dropped a bit or saturated one count early would miss that value, and the high-limit flag would stay clear against a threshold of 32767. It pulses clear strobes at random, including in cycles where a comparator fires, so a design where clear wins over set loses a flag that should have stuck. The skip-count phases catch a design that compares the start-up transient and raises early limit events. The zero-crossing phases start from a previous amplitude of 0, so a detector that reset its history wrongly, or fired on level instead of on a rise, shows up as extra or missing flag-2 events.

// File: rtl/amp_cmp_pkg.sv
package amp_cmp_pkg;
   typedef enum logic [1:0] {
      ORD_SINC1 = 2'd0,
      ORD_SINC2 = 2'd1,
      ORD_SINC3 = 2'd2,
      ORD_FAST  = 2'd3
   } ord_e;

   localparam int FLG_HI = 0;
   localparam int FLG_LO = 1;
   localparam int FLG_ZC = 2;
   localparam int FLG_MF = 3;
   localparam int FLG_N  = 4;

   // integrator / comb stages needed by the highest order
   localparam int SINC_STAGES = 3;
endpackage

// File: rtl/amp_sinc.sv
module amp_sinc
   import amp_cmp_pkg::*;
#(
   parameter int AMP_W   = 16,
   parameter int RATIO_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             bit_vld,
   input  logic             bit_in,
   input  logic [1:0]       order,
   input  logic [RATIO_W-1:0] ratio,
   output logic [AMP_W-1:0] amp_o,
   output logic             amp_vld_o
);
   localparam int ACC_W = AMP_W + 1;
   localparam int CNT_W = RATIO_W + 1;
   localparam int RMAX  = 1 << RATIO_W;
   localparam int NS    = SINC_STAGES;
   localparam int PRD_W = ACC_W + CNT_W;

   if (AMP_W < NS * RATIO_W + 1) begin : g_bad_width
      $error("amp_sinc: AMP_W too narrow for third-order full scale");
   end
   if (RATIO_W < 1) begin : g_bad_ratio
      $error("amp_sinc: RATIO_W must be at least 1");
   end

   logic [CNT_W-1:0] ratio_eff;
   logic [CNT_W-1:0] cnt_q;
   logic             dec;
   logic [ACC_W-1:0] integ_q  [NS];
   logic [ACC_W-1:0] integ_nx [NS];
   logic [ACC_W-1:0] cz_q     [NS];
   logic [ACC_W-1:0] cdiff    [NS];
   logic [ACC_W-1:0] src;
   logic [ACC_W-1:0] res_sel;
   logic [PRD_W-1:0] prod;
   logic [AMP_W-1:0] amp_nx;
   logic [1:0]       stg_idx;

   assign ratio_eff = (ratio == '0) ? CNT_W'(RMAX) : {1'b0, ratio};
   assign dec       = en && bit_vld && (cnt_q == ratio_eff - 1'b1);
   assign stg_idx   = (order == ORD_FAST) ? 2'd1 : order;

   // integrator cascade, each stage fed by the updated value of the previous one
   for (genvar g = 0; g < NS; g++) begin : g_integ
      if (g == 0) begin : g_first
         assign integ_nx[g] = integ_q[g] + ACC_W'(bit_in);
      end else begin : g_next
         assign integ_nx[g] = integ_q[g] + integ_nx[g-1];
      end
   end

   always_comb begin
      src = integ_nx[0];
      res_sel = cdiff[0];
      for (int k = 0; k < NS; k++) begin
         if (stg_idx == 2'(k)) begin
            src = integ_nx[k];
            res_sel = cdiff[k];
         end
      end
   end

   // comb cascade
   for (genvar g = 0; g < NS; g++) begin : g_comb
      if (g == 0) begin : g_first
         assign cdiff[g] = src - cz_q[g];
      end else begin : g_next
         assign cdiff[g] = cdiff[g-1] - cz_q[g];
      end
   end

   assign prod   = PRD_W'(res_sel) * PRD_W'(ratio_eff);
   assign amp_nx = (order == ORD_FAST) ? AMP_W'(prod) : AMP_W'(res_sel);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt_q     <= '0;
         amp_o     <= '0;
         amp_vld_o <= 1'b0;
         for (int k = 0; k < NS; k++) begin
            integ_q[k] <= '0;
            cz_q[k]    <= '0;
         end
      end else begin
         amp_vld_o <= dec;
         if (bit_vld) begin
            for (int k = 0; k < NS; k++) integ_q[k] <= integ_nx[k];
            cnt_q <= dec ? '0 : cnt_q + 1'b1;
         end
         if (dec) begin
            amp_o <= amp_nx;
            cz_q[0] <= src;
            for (int k = 1; k < NS; k++) cz_q[k] <= cdiff[k-1];
         end
      end
   end

   // R4: a disabled path shows zero amplitude and no strobe
   assert_cleared_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (amp_o == '0) && !amp_vld_o);

   // R1: first-order result never exceeds the window length
   assert_sinc1_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (amp_vld_o && order == ORD_SINC1 && $stable(order) && $stable(ratio))
         |-> (AMP_W'(amp_o) <= AMP_W'(ratio_eff)));
endmodule

// File: rtl/amp_cmp.sv
module amp_cmp
   import amp_cmp_pkg::*;
#(
   parameter int AMP_W = 16,
   parameter int IGN_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [AMP_W-1:0] amp_i,
   input  logic             amp_vld_i,
   input  logic [IGN_W-1:0] ign_cnt,
   input  logic [AMP_W-1:0] thr_hi,
   input  logic [AMP_W-1:0] thr_lo,
   input  logic [AMP_W-1:0] thr_zc,
   input  logic             zc_en,
   input  logic             clk_missing,
   input  logic [FLG_N-1:0] clr,
   output logic [FLG_N-1:0] flags_o
);
   if (IGN_W < 1) begin : g_bad_ign
      $error("amp_cmp: IGN_W must be at least 1");
   end

   logic [IGN_W-1:0] ign_left_q;
   logic [AMP_W-1:0] prev_q;
   logic             act;
   logic [FLG_N-1:0] set;

   assign act         = en && amp_vld_i && (ign_left_q == '0);
   assign set[FLG_HI] = act && (amp_i > thr_hi);
   assign set[FLG_LO] = act && (amp_i < thr_lo);
   assign set[FLG_ZC] = act && zc_en && (prev_q <= thr_zc) && (amp_i > thr_zc);
   assign set[FLG_MF] = en && clk_missing;

   // one sticky cell per flag; a set in the clearing cycle wins
   for (genvar f = 0; f < FLG_N; f++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n) flags_o[f] <= 1'b0;
         else        flags_o[f] <= (flags_o[f] && !clr[f]) || set[f];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ign_left_q <= '0;
         prev_q     <= '0;
      end else if (!en) begin
         ign_left_q <= ign_cnt;
         prev_q     <= '0;
      end else if (amp_vld_i) begin
         prev_q <= amp_i;
         if (ign_left_q != '0) ign_left_q <= ign_left_q - 1'b1;
      end
   end

   // R10: an uncleared flag never drops
   assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o & ~clr) != '0 |=> ((flags_o & $past(flags_o & ~clr)) == $past(flags_o & ~clr)));

   // R6: high flag rises only after an amplitude above the threshold
   assert_hi_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[FLG_HI]) |-> $past(amp_vld_i && (amp_i > thr_hi)));

   // R7: low flag rises only after an amplitude below the threshold
   assert_lo_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[FLG_LO]) |-> $past(amp_vld_i && (amp_i < thr_lo)));

   // R8: zero-crossing flag needs its enable
   assert_zc_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[FLG_ZC]) |-> $past(zc_en && amp_vld_i));

   // R9: clock loss while enabled is always recorded
   assert_fail_seen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && clk_missing) |=> flags_o[FLG_MF]);

   // R5: a skipped amplitude cannot raise the high flag
   assert_skip_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (amp_vld_i && ign_left_q != '0 && !flags_o[FLG_HI]) |=> !flags_o[FLG_HI]);
endmodule

// File: rtl/amp_threshold_monitor.sv
module amp_threshold_monitor
   import amp_cmp_pkg::*;
#(
   parameter int AMP_W   = 16,
   parameter int RATIO_W = 5,
   parameter int IGN_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               path_en,
   input  logic               bit_vld,
   input  logic               bit_in,
   input  logic [1:0]         filt_order,
   input  logic [RATIO_W-1:0] dec_ratio,
   input  logic [IGN_W-1:0]   skip_cnt,
   input  logic [AMP_W-1:0]   thr_high,
   input  logic [AMP_W-1:0]   thr_low,
   input  logic [AMP_W-1:0]   thr_zero,
   input  logic               zc_en,
   input  logic               ie_high,
   input  logic               ie_low,
   input  logic               ie_fail,
   input  logic               mclk_lost,
   input  logic [FLG_N-1:0]   flag_clr,
   output logic [AMP_W-1:0]   amp,
   output logic               amp_vld,
   output logic [FLG_N-1:0]   flags,
   output logic               irq
);
   amp_sinc #(.AMP_W(AMP_W), .RATIO_W(RATIO_W)) u_sinc (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (path_en),
      .bit_vld   (bit_vld),
      .bit_in    (bit_in),
      .order     (filt_order),
      .ratio     (dec_ratio),
      .amp_o     (amp),
      .amp_vld_o (amp_vld)
   );

   amp_cmp #(.AMP_W(AMP_W), .IGN_W(IGN_W)) u_cmp (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (path_en),
      .amp_i       (amp),
      .amp_vld_i   (amp_vld),
      .ign_cnt     (skip_cnt),
      .thr_hi      (thr_high),
      .thr_lo      (thr_low),
      .thr_zc      (thr_zero),
      .zc_en       (zc_en),
      .clk_missing (mclk_lost),
      .clr         (flag_clr),
      .flags_o     (flags)
   );

   assign irq = (flags[FLG_HI] && ie_high) || (flags[FLG_LO] && ie_low) ||
                (flags[FLG_MF] && ie_fail);

   // R11: a lone zero-crossing flag keeps the interrupt low
   assert_zc_no_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == 4'b0100) |-> !irq);
endmodule

// File: tb/amp_threshold_monitor_bench.sv
`timescale 1ns/1ps
module amp_threshold_monitor_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        path_en, bit_vld, bit_in, zc_en, ie_high, ie_low, ie_fail, mclk_lost;
   logic [1:0]  filt_order;
   logic [4:0]  dec_ratio;
   logic [2:0]  skip_cnt;
   logic [15:0] thr_high, thr_low, thr_zero;
   logic [3:0]  flag_clr;
   logic [15:0] amp;
   logic        amp_vld, irq;
   logic [3:0]  flags;

   always #10 clk = ~clk;

   amp_threshold_monitor u_amp_threshold_monitor (
      .clk(clk), .rst_n(rst_n), .path_en(path_en), .bit_vld(bit_vld), .bit_in(bit_in),
      .filt_order(filt_order), .dec_ratio(dec_ratio), .skip_cnt(skip_cnt),
      .thr_high(thr_high), .thr_low(thr_low), .thr_zero(thr_zero), .zc_en(zc_en),
      .ie_high(ie_high), .ie_low(ie_low), .ie_fail(ie_fail), .mclk_lost(mclk_lost),
      .flag_clr(flag_clr), .amp(amp), .amp_vld(amp_vld), .flags(flags), .irq(irq));

   int    n_vec = 0, n_bad = 0;
   bit    done = 0;
   string phase = "reset";

   // reference model state
   int hist[$];
   int wts[$];
   int nsmp = 0, m_amp = 0, m_prev = 0, m_ign = 0, m_flags = 0;
   bit m_avld = 0;

   function automatic int r_of(int code);
      return (code == 0) ? 32 : code;
   endfunction

   // impulse response: box of length R convolved with itself (order) times
   function automatic void build_wts(int ord, int r);
      int box[$];
      int cur[$];
      int stages;
      for (int i = 0; i < r; i++) box.push_back(1);
      cur = box;
      stages = (ord == 3) ? 2 : ord + 1;
      for (int s = 1; s < stages; s++) begin
         int nxt[$];
         for (int i = 0; i < cur.size() + r - 1; i++) nxt.push_back(0);
         for (int i = 0; i < cur.size(); i++)
            for (int j = 0; j < r; j++) nxt[i+j] += cur[i];
         cur = nxt;
      end
      if (ord == 3) for (int i = 0; i < cur.size(); i++) cur[i] *= r;
      wts = cur;
   endfunction

   task automatic model_update();
      int set = 0;
      bit act = path_en && m_avld && (m_ign == 0);
      if (act) begin
         if (m_amp > int'(thr_high)) set |= 1;
         if (m_amp < int'(thr_low)) set |= 2;
         if (zc_en && m_prev <= int'(thr_zero) && m_amp > int'(thr_zero)) set |= 4;
      end
      if (path_en && mclk_lost) set |= 8;
      m_flags = ((m_flags & ~int'(flag_clr)) | set) & 15;
      if (!path_en) begin
         m_ign = int'(skip_cnt); m_prev = 0; hist.delete(); nsmp = 0;
         m_amp = 0; m_avld = 0;
      end else begin
         if (m_avld) begin
            m_prev = m_amp;
            if (m_ign > 0) m_ign--;
         end
         m_avld = 0;
         if (bit_vld) begin
            hist.push_back(int'(bit_in));
            nsmp++;
            if (nsmp % r_of(int'(dec_ratio)) == 0) begin
               int acc = 0;
               for (int k = 0; k < wts.size(); k++) begin
                  int idx = hist.size() - 1 - k;
                  if (idx >= 0) acc += wts[k] * hist[idx];
               end
               m_amp = acc & 16'hFFFF;
               m_avld = 1;
            end
         end
      end
   endtask

   task automatic chk(string req, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s [phase %s] at %0t: got %0d expected %0d", req, phase, $time, act, exp);
      end
   endtask

   task automatic compare();
      string areq;
      int exp_irq;
      areq = (filt_order == 2'd0) ? "R1" : (filt_order == 2'd3) ? "R3" : "R2";
      chk(areq, int'(amp), m_amp);
      chk("R4 strobe", int'(amp_vld), int'(m_avld));
      chk("R6 high flag", int'(flags[0]), m_flags & 1);
      chk("R7 low flag", int'(flags[1]), (m_flags >> 1) & 1);
      chk("R8 zero-crossing flag", int'(flags[2]), (m_flags >> 2) & 1);
      chk("R9 failure flag", int'(flags[3]), (m_flags >> 3) & 1);
      exp_irq = (((m_flags & 1) != 0 && ie_high) || ((m_flags & 2) != 0 && ie_low) ||
                 ((m_flags & 8) != 0 && ie_fail)) ? 1 : 0;
      chk("R11 irq", int'(irq), exp_irq);
   endtask

   task automatic step();
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare();
   endtask

   // mode 0: random bits, 1: all ones, 2: random bits plus random clock loss
   task automatic run_phase(string tag, int ord, int rcode, int ign, int hi, int lo,
                            int zc, bit zce, int ncyc, int mode);
      phase = tag;
      filt_order = 2'(ord); dec_ratio = 5'(rcode); skip_cnt = 3'(ign);
      thr_high = 16'(hi); thr_low = 16'(lo); thr_zero = 16'(zc); zc_en = zce;
      ie_high = 1'($urandom_range(0, 1)); ie_low = 1'($urandom_range(0, 1));
      ie_fail = 1'($urandom_range(0, 1));
      build_wts(ord, r_of(rcode));
      path_en = 0; bit_vld = 0; bit_in = 0; mclk_lost = 0; flag_clr = 4'hF;
      for (int c = 0; c < 3; c++) step();
      flag_clr = 4'h0;
      path_en = 1;
      for (int c = 0; c < ncyc; c++) begin
         bit_vld = (mode == 1) ? 1'b1 : 1'($urandom_range(0, 3) != 0);
         bit_in = (mode == 1) ? 1'b1 : 1'($urandom_range(0, 1));
         mclk_lost = (mode == 2) ? 1'($urandom_range(0, 15) == 0) : 1'b0;
         // R10: random write-1 clears, often landing on set cycles
         flag_clr = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
         step();
      end
      mclk_lost = 0; flag_clr = 4'h0; bit_vld = 0;
   endtask

   initial begin
      rst_n = 0; path_en = 0; bit_vld = 0; bit_in = 0; filt_order = 0; dec_ratio = 4;
      skip_cnt = 0; thr_high = 0; thr_low = 0; thr_zero = 0; zc_en = 0; ie_high = 1;
      ie_low = 1; ie_fail = 1; mclk_lost = 0; flag_clr = 0;
      repeat (4) @(negedge clk);
      // reset state: R4 amplitude cleared, R10 flags cleared
      chk("R4 reset amp", int'(amp), 0);
      chk("R4 reset strobe", int'(amp_vld), 0);
      chk("R10 reset flags", int'(flags), 0);
      chk("R11 reset irq", int'(irq), 0);
      rst_n = 1;
      run_phase("R1 first order", 0, 4, 0, 3, 1, 2, 1, 1500, 0);
      run_phase("R1 ratio one", 0, 1, 0, 0, 1, 0, 1, 300, 0);
      run_phase("R2 second order ratio 32", 1, 0, 0, 700, 300, 512, 1, 2500, 0);
      run_phase("R2 third order", 2, 6, 0, 150, 60, 108, 1, 2000, 0);
      run_phase("R2 third order full scale", 2, 0, 0, 32767, 0, 16384, 1, 400, 1);
      run_phase("R3 fast", 3, 8, 0, 3000, 1000, 2048, 1, 2000, 0);
      run_phase("R5 skip start", 2, 5, 3, 60, 40, 62, 1, 1500, 0);
      run_phase("R8 zc disabled", 0, 4, 0, 9, 0, 1, 0, 800, 0);
      run_phase("R9 clock loss", 1, 5, 1, 20, 5, 12, 1, 1500, 2);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog [phase %s]: got timeout expected completion", phase);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule